// File: doc/BRIEF.md
# Multi-cycle SUBLEQ processor core

This block is a processor with a single instruction: subtract and branch if the result is less than or equal to zero. An instruction takes three consecutive memory words, A, B and C, and carries no opcode. The core reads the word stored at address A and the word stored at address B. It stores their difference, B minus A, back at address B. If that difference is zero or negative, execution continues at C. Otherwise it continues at the word after the instruction.

A 3-bit step counter runs the core through eight fixed one-clock steps. The counter wraps from 7 back to 0, and each instruction takes exactly eight clocks. Every memory access goes to one single-port unified memory that answers a read one clock after the address is presented. One address is reserved for output (all ones by default). A write aimed at that address does not go to memory. Instead, the difference appears on an output port together with a one-cycle strobe. A halt input freezes the core at any step. When halt is released, the instruction resumes and produces the same result it would have produced without the halt.

Top module: `subleq_core`

## Requirements
- R1: A synchronous reset sets the step counter to 0 and the program counter to 0. After reset, mem_addr is 0 and mem_we and out_valid are low.
- R2: In steps 0, 1 and 2, mem_addr is PC, PC+1 and PC+2, computed modulo 2^DATA_W. The words that come back are kept as the addresses A, B and C.
- R3: In step 3, mem_addr is A. In step 4, mem_addr is B. The data returned for these two reads are the operands.
- R4: In step 6 only, mem_we is high for one cycle. It writes Mem[B] - Mem[A], computed modulo 2^DATA_W, to address B.
- R5: If the difference has its sign bit set or is zero, the next instruction is fetched from C. The PC changes only in step 7.
- R6: If the difference is positive, the next instruction is fetched from PC+3, computed modulo 2^DATA_W.
- R7: If B equals OUT_ADDR, mem_we stays low for that instruction. out_valid pulses for exactly one cycle in step 6, with out_data equal to the difference, and the branch rule still applies.
- R8: The step counter counts 0 to 7 and wraps to 0. The next instruction's fetch appears exactly eight clocks after the previous one.
- R9: While halt is high, the step counter and the PC hold, mem_addr holds, and mem_we and out_valid stay low. After halt is released, the instruction completes with the result it would have had without the halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Freezes the core while high |
| mem_addr | output | DATA_W | Memory address for the current step |
| mem_rdata | input | DATA_W | Read data, valid one clock after the address |
| mem_wdata | output | DATA_W | Write data (the difference) |
| mem_we | output | 1 | Memory write enable |
| out_valid | output | 1 | One-cycle strobe for a write to the output address |
| out_data | output | DATA_W | The difference sent to the output address; zero when out_valid is low |

## Verification
The bench builds the core with DATA_W = 8 and OUT_ADDR = 8'hFF. With these values, a 256-word array in the bench models the whole address space exactly. Signed overflow of the difference, the wrap of PC+3 past the top of memory and a fetch that reads the reserved output address as an instruction word can all be reached with a few instructions. The bench also places a halt in the step right after the first fetch, where the read data must be held until halt is released.

// File: rtl/subleq_pkg.sv
package subleq_pkg;

  localparam int STEP_W      = 3;
  localparam int STEP_N      = 1 << STEP_W;
  localparam int FETCH_WORDS = 3;
  localparam int CAPTURE_N   = 5;

  typedef enum logic [STEP_W-1:0] {
    ST_FETCH_A  = 3'd0,
    ST_FETCH_B  = 3'd1,
    ST_FETCH_C  = 3'd2,
    ST_READ_A   = 3'd3,
    ST_READ_B   = 3'd4,
    ST_CAPTURE  = 3'd5,
    ST_WRITE    = 3'd6,
    ST_BRANCH   = 3'd7
  } step_e;

endpackage

// File: rtl/subleq_stepper.sv
module subleq_stepper
  import subleq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  output step_e             step,
  output logic [STEP_W-1:0] step_bits,
  output logic [STEP_N-1:0] step_hot
);

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= ST_FETCH_A;
    end else if (run) begin
      step <= step_e'(step_bits + STEP_W'(1));
    end
  end

  assign step_bits = step;

  // One enable line per step.
  for (genvar i = 0; i < STEP_N; i++) begin : g_dec
    assign step_hot[i] = (step_bits == STEP_W'(i));
  end

endmodule

// File: rtl/subleq_read_hold.sv
module subleq_read_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] rd_eff
);

  // The memory answers the address of the previous cycle. During a halt,
  // mem_addr holds the current step's address, so the answer that belongs
  // to the last running cycle is kept here until the core runs again.
  logic              ran_q;
  logic [DATA_W-1:0] keep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ran_q  <= 1'b1;
      keep_q <= '0;
    end else begin
      ran_q <= run;
      if (ran_q) keep_q <= rdata;
    end
  end

  assign rd_eff = ran_q ? rdata : keep_q;

endmodule

// File: rtl/subleq_operands.sv
module subleq_operands
  import subleq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic [CAPTURE_N-1:0] cap_en,
  input  logic [DATA_W-1:0]    rd_data,
  output logic [DATA_W-1:0]    addr_a,
  output logic [DATA_W-1:0]    addr_b,
  output logic [DATA_W-1:0]    addr_c,
  output logic [DATA_W-1:0]    val_a,
  output logic [DATA_W-1:0]    val_b
);

  // Slot k captures in step k+1: A, B, C addresses, then Mem[A], Mem[B].
  logic [DATA_W-1:0] slot_q [CAPTURE_N];

  for (genvar k = 0; k < CAPTURE_N; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q[k] <= '0;
      end else if (run && cap_en[k]) begin
        slot_q[k] <= rd_data;
      end
    end
  end

  assign addr_a = slot_q[0];
  assign addr_b = slot_q[1];
  assign addr_c = slot_q[2];
  assign val_a  = slot_q[3];
  assign val_b  = slot_q[4];

endmodule

// File: rtl/subleq_alu.sv
module subleq_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] minuend,
  input  logic [DATA_W-1:0] subtrahend,
  output logic [DATA_W-1:0] diff,
  output logic              non_positive
);

  function automatic logic [DATA_W-1:0] sub_wrap(
    input logic [DATA_W-1:0] m,
    input logic [DATA_W-1:0] s
  );
    return m - s;
  endfunction

  function automatic logic is_le_zero(input logic [DATA_W-1:0] v);
    return v[DATA_W-1] | (v == '0);
  endfunction

  assign diff         = sub_wrap(minuend, subtrahend);
  assign non_positive = is_le_zero(diff);

endmodule

// File: rtl/subleq_pc.sv
module subleq_pc
  import subleq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              take,
  input  logic [DATA_W-1:0] target,
  input  logic [STEP_W-1:0] step_bits,
  output logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] fetch_addr
);

  function automatic logic [DATA_W-1:0] next_pc(
    input logic [DATA_W-1:0] cur,
    input logic              br,
    input logic [DATA_W-1:0] dst
  );
    return br ? dst : cur + DATA_W'(FETCH_WORDS);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (load_en) begin
      pc <= next_pc(pc, take, target);
    end
  end

  assign fetch_addr = pc + DATA_W'(step_bits);

endmodule

// File: rtl/subleq_core.sv
module subleq_core
  import subleq_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter logic [DATA_W-1:0] OUT_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  output logic [DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic              run;
  step_e             step_q;
  logic [STEP_W-1:0] step_bits;
  logic [STEP_N-1:0] step_hot;
  logic [DATA_W-1:0] rd_eff;
  logic [DATA_W-1:0] addr_a, addr_b, addr_c, val_a, val_b;
  logic [DATA_W-1:0] diff;
  logic              non_positive;
  logic [DATA_W-1:0] pc_q, fetch_addr;
  logic              fetch_phase;
  logic              write_step;
  logic              out_target;
  logic              pc_load;

  assign run = ~halt;

  subleq_stepper u_step (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .step      (step_q),
    .step_bits (step_bits),
    .step_hot  (step_hot)
  );

  subleq_read_hold #(.DATA_W(DATA_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .rdata  (mem_rdata),
    .rd_eff (rd_eff)
  );

  subleq_operands #(.DATA_W(DATA_W)) u_opnd (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .cap_en  (step_hot[CAPTURE_N:1]),
    .rd_data (rd_eff),
    .addr_a  (addr_a),
    .addr_b  (addr_b),
    .addr_c  (addr_c),
    .val_a   (val_a),
    .val_b   (val_b)
  );

  subleq_alu #(.DATA_W(DATA_W)) u_alu (
    .minuend      (val_b),
    .subtrahend   (val_a),
    .diff         (diff),
    .non_positive (non_positive)
  );

  assign pc_load = run & step_hot[ST_BRANCH];

  subleq_pc #(.DATA_W(DATA_W)) u_pc (
    .clk        (clk),
    .rst        (rst),
    .load_en    (pc_load),
    .take       (non_positive),
    .target     (addr_c),
    .step_bits  (step_bits),
    .pc         (pc_q),
    .fetch_addr (fetch_addr)
  );

  assign fetch_phase = step_hot[ST_FETCH_A] | step_hot[ST_FETCH_B] | step_hot[ST_FETCH_C];

  always_comb begin
    if (fetch_phase) begin
      mem_addr = fetch_addr;
    end else if (step_hot[ST_READ_A]) begin
      mem_addr = addr_a;
    end else begin
      mem_addr = addr_b;
    end
  end

  assign write_step = run & step_hot[ST_WRITE];
  assign out_target = (addr_b == OUT_ADDR);
  assign mem_wdata  = diff;
  assign mem_we     = write_step & ~out_target;
  assign out_valid  = write_step & out_target;
  assign out_data   = out_valid ? diff : '0;

endmodule

// File: rtl/subleq_core_checker.sv
module subleq_core_checker #(
  parameter int                DATA_W   = 16,
  parameter logic [DATA_W-1:0] OUT_ADDR = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              halt,
  input logic [2:0]        step_code,
  input logic [DATA_W-1:0] pc,
  input logic [DATA_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              out_valid
);

  assert_we_in_write_step_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (step_code == 3'd6 && !halt));

  assert_pc_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (step_code != 3'd7) |=> $stable(pc));

  assert_out_single_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_no_mem_write_to_out_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr != OUT_ADDR));

  assert_step_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (!halt && !$past(rst)) |=> (step_code == 3'($past(step_code) + 3'd1)));

  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (rst)
    halt |=> ($stable(step_code) && $stable(pc) && $stable(mem_addr)));

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    halt |-> (!mem_we && !out_valid));

endmodule

bind subleq_core subleq_core_checker #(.DATA_W(DATA_W), .OUT_ADDR(OUT_ADDR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .halt      (halt),
  .step_code (step_bits),
  .pc        (pc_q),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .out_valid (out_valid)
);

// File: tb/sim_subleq_core.sv
`timescale 1ns/1ps
module sim_subleq_core;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         halt = 1'b0;
  logic [W-1:0] mem_addr, mem_rdata, mem_wdata, out_data;
  logic         mem_we, out_valid;

  logic [W-1:0] mem [256];
  int           we_cnt, out_cnt;
  int           checks = 0;
  int           errors = 0;

  always #2 clk = ~clk;

  subleq_core #(.DATA_W(W), .OUT_ADDR(8'hFF)) u0 (
    .clk       (clk),
    .rst       (rst),
    .halt      (halt),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // One-port memory, read data valid one clock after the address.
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    if (rst) begin
      we_cnt  <= 0;
      out_cnt <= 0;
    end else begin
      if (mem_we)    we_cnt  <= we_cnt + 1;
      if (out_valid) out_cnt <= out_cnt + 1;
    end
  end

  // Fields: A, B, C, Mem[A], Mem[B].
  localparam logic [39:0] VEC [7] = '{
    {8'd10, 8'd11, 8'd40, 8'h03, 8'h05},
    {8'd10, 8'd11, 8'd40, 8'h05, 8'h05},
    {8'd10, 8'd11, 8'd40, 8'h07, 8'h02},
    {8'd20, 8'd21, 8'd60, 8'h01, 8'h80},
    {8'd20, 8'd21, 8'd60, 8'hFF, 8'h7F},
    {8'd30, 8'd31, 8'd90, 8'h00, 8'h01},
    {8'd12, 8'd12, 8'd70, 8'h09, 8'h09}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start(input logic [W-1:0] ia, input logic [W-1:0] ib,
                       input logic [W-1:0] ic, input logic [W-1:0] av,
                       input logic [W-1:0] bv);
    rst = 1'b1;
    halt = 1'b0;
    tick(1);
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[0] = ia; mem[1] = ib; mem[2] = ic;
    mem[ia] = av; mem[ib] = bv;
    tick(2);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] e_diff, e_pc;

    // Reset state and the order of the addresses for fetch and operands.
    start(8'd10, 8'd11, 8'd40, 8'h03, 8'h05);
    chk("R1 mem_addr after reset", mem_addr, 0);
    chk("R1 mem_we after reset", mem_we, 0);
    chk("R1 out_valid after reset", out_valid, 0);
    tick(1); chk("R2 fetch PC+1", mem_addr, 1);
    tick(1); chk("R2 fetch PC+2", mem_addr, 2);
    tick(1); chk("R3 read address A", mem_addr, 10);
    tick(1); chk("R3 read address B", mem_addr, 11);

    // Walk the vector table.
    for (int v = 0; v < 7; v++) begin
      logic [W-1:0] ia, ib, ic, av, bv;
      {ia, ib, ic, av, bv} = VEC[v];
      e_diff = bv - av;
      e_pc   = (e_diff[W-1] || e_diff == '0) ? ic : 8'd3;
      start(ia, ib, ic, av, bv);
      tick(7);
      chk($sformatf("R4 Mem[B] vec%0d", v), mem[ib], e_diff);
      tick(1);
      chk($sformatf("R5 R6 R8 next fetch vec%0d", v), mem_addr, e_pc);
    end

    // Taken branch near the top of memory, then PC+3 wraps to 0.
    start(8'h10, 8'h11, 8'hFD, 8'h01, 8'h01);
    mem[8'hFD] = 8'h20; mem[8'hFE] = 8'h21; mem[8'hFF] = 8'h30;
    mem[8'h20] = 8'h00; mem[8'h21] = 8'h01;
    tick(8); chk("R5 branch to C", mem_addr, 8'hFD);
    tick(8); chk("R6 PC+3 wraps", mem_addr, 8'h00);

    // Output redirection: 5 - 20 = -15 = F1, taken.
    start(8'h10, 8'hFF, 8'h50, 8'd20, 8'd5);
    tick(6);
    chk("R7 out_valid in write step", out_valid, 1);
    chk("R7 out_data", out_data, 8'hF1);
    tick(1);
    chk("R7 out_valid single pulse", out_valid, 0);
    tick(1);
    chk("R7 R5 next fetch", mem_addr, 8'h50);
    chk("R7 reserved word untouched", mem[8'hFF], 8'd5);
    chk("R7 no memory write", we_cnt, 0);
    chk("R7 one strobe", out_cnt, 1);

    // Halt right after the first fetch: the word for A must survive.
    start(8'h10, 8'h11, 8'h40, 8'd3, 8'd9);
    tick(1);
    halt = 1'b1;
    tick(10);
    chk("R9 mem_addr held", mem_addr, 1);
    chk("R9 no write while halted", we_cnt, 0);
    halt = 1'b0;
    tick(6);
    chk("R9 result after resume", mem[8'h11], 8'd6);
    tick(1);
    chk("R9 next fetch after resume", mem_addr, 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule